// File: doc/BRIEF.md
# Linear Frequency Sweep Sequencer

This block steps a 24-bit frequency word through a linear scan for a phase-accumulator waveform source. A rising edge on the trigger input starts a scan: the word is loaded with the start value, and then the delta value is added to it a programmed number of times. The steps are paced either by an internal interval counter or by further rising edges of the same trigger input. A configuration pin selects the pacing. After the last step the sequencer stops and holds the final word until the next trigger starts a new scan.

A sync indication goes out alongside the word. It has two modes. In the first it gives a fixed 4-cycle high pulse at every step. In the second it is a level that rises when the scan completes and falls when the next scan starts. A separate enable controls a pad output-enable, so the pad ring can put the sync pin in high impedance. Programming of the configuration values and waveform synthesis are handled outside this block.

The frequency word is a continuously valid level that the downstream accumulator samples every cycle. It therefore has no valid/ready handshake and no back-pressure. All configuration and status pins are plain levels. The configuration pins are expected to stay stable while a scan runs.

Top module: `freq_sweep_ctrl`

## Requirements
- R1: Out of reset `freq_word` is 0, `scan_busy` and `scan_done` are 0 and `sync_out` is 0. The trigger input passes through two synchronizer flops. A rising edge of the synchronized trigger, seen while no scan is running, loads `freq_word` with `start_freq` and raises `scan_busy`. Both changes appear on the third rising clock edge after the trigger input goes high.
- R2: Each step sets `freq_word` to `freq_word + delta_freq` modulo 2^24, so the word wraps past 0xFFFFFF.
- R3: A scan makes exactly `num_steps` steps. After the last step `scan_busy` falls, `scan_done` rises and `freq_word` holds its value. With `num_steps` = 0 the scan goes straight to the done state, holding `start_freq`.
- R4: With `ext_pace` = 0, steps come every `step_interval` + 1 cycles. The first step comes that many cycles after the start load. Trigger edges during an internally paced scan are ignored.
- R5: With `ext_pace` = 1, each rising edge of the synchronized trigger during a scan makes exactly one step. That step appears on the third rising clock edge after the trigger input goes high. A trigger held high makes only one step.
- R6: With `sync_eos_mode` = 0, `sync_out` is high for exactly 4 cycles, starting on the same clock edge as each step's change of `freq_word`.
- R7: With `sync_eos_mode` = 1, `sync_out` is low while a scan runs. It goes high on the edge that completes the scan and stays high until the edge that starts the next scan.
- R8: With `sync_en` = 0, `sync_oe` is 0 and `sync_out` is 0 whatever the scan does. With `sync_en` = 1, `sync_oe` is 1.
- R9: A trigger edge in the done state restarts the scan from `start_freq`, under the same timing as R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_in | input | 1 | Asynchronous start/step trigger |
| ext_pace | input | 1 | 1: steps paced by trigger edges; 0: by interval counter |
| sync_eos_mode | input | 1 | 1: end-of-scan level; 0: 4-cycle pulse per step |
| sync_en | input | 1 | Enables the sync pad driver |
| start_freq | input | 24 | Frequency word loaded at scan start |
| delta_freq | input | 24 | Increment added at each step |
| num_steps | input | 12 | Number of steps in a scan |
| step_interval | input | 16 | Internal pacing: cycles between steps minus one |
| freq_word | output | 24 | Current frequency word |
| scan_busy | output | 1 | Scan in progress |
| scan_done | output | 1 | Scan finished, word held |
| sync_out | output | 1 | Sync data toward the pad |
| sync_oe | output | 1 | Sync pad output-enable; 0 means high impedance |

## Verification
The scan is run with internal pacing at an interval of six. This separates the step period from the 4-cycle pulse, and it shows that a stray trigger in mid-scan leaves the step timing unchanged. A zero interval with a start value near the top of the range produces a step every cycle and checks the 24-bit wraparound together with the end-of-scan level and its clearing on restart. Externally paced steps are driven with the trigger held high for several cycles and then toggled, which tells one event per edge apart from level-sensitive stepping. A zero-step scan and a scan with sync disabled cover the degenerate count and the pad enable.

// File: rtl/fsweep_pkg.sv
package fsweep_pkg;
  typedef enum logic [1:0] {
    SW_IDLE = 2'd0,
    SW_RUN  = 2'd1,
    SW_DONE = 2'd2
  } sweep_state_e;
endpackage

// File: rtl/sweep_edge_det.sv
module sweep_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // R5
  single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/sweep_pacer.sv
module sweep_pacer #(
  parameter int IVL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic             ext_mode,
  input  logic             ext_evt,
  input  logic [IVL_W-1:0] interval,
  output logic             step_o
);
  logic [IVL_W-1:0] cnt_q;

  assign step_o = run && (ext_mode ? ext_evt : (cnt_q == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start || step_o) begin
      cnt_q <= interval;
    end else if (run && cnt_q != '0) begin
      cnt_q <= cnt_q - IVL_W'(1);
    end
  end

  // R4
  interval_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && !ext_mode && interval != '0) |=> (!step_o || ext_mode));
endmodule

// File: rtl/sweep_sync_gen.sv
module sweep_sync_gen #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_evt,
  input  logic scan_start,
  input  logic scan_end,
  input  logic eos_mode,
  input  logic enable,
  output logic sync_o,
  output logic sync_oe_o
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] pcnt_q;
  logic          eos_q;
  logic          pulse_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else if (step_evt) begin
      pcnt_q <= PW'(PULSE_LEN);
    end else if (pcnt_q != '0) begin
      pcnt_q <= pcnt_q - PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eos_q <= 1'b0;
    end else if (scan_end) begin
      eos_q <= 1'b1;
    end else if (scan_start) begin
      eos_q <= 1'b0;
    end
  end

  assign pulse_on  = (pcnt_q != '0);
  assign sync_o    = enable & (eos_mode ? eos_q : pulse_on);
  assign sync_oe_o = enable;

  // R6
  pulse_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> pulse_on);

  // R7
  eos_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_start && !scan_end) |=> !eos_q);
endmodule

// File: rtl/freq_sweep_ctrl.sv
module freq_sweep_ctrl #(
  parameter int FREQ_W      = 24,
  parameter int STEP_W      = 12,
  parameter int IVL_W       = 16,
  parameter int PULSE_LEN   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_in,
  input  logic              ext_pace,
  input  logic              sync_eos_mode,
  input  logic              sync_en,
  input  logic [FREQ_W-1:0] start_freq,
  input  logic [FREQ_W-1:0] delta_freq,
  input  logic [STEP_W-1:0] num_steps,
  input  logic [IVL_W-1:0]  step_interval,
  output logic [FREQ_W-1:0] freq_word,
  output logic              scan_busy,
  output logic              scan_done,
  output logic              sync_out,
  output logic              sync_oe
);
  import fsweep_pkg::*;

  sweep_state_e      state_q;
  logic [FREQ_W-1:0] freq_q;
  logic [STEP_W-1:0] left_q;
  logic              trig_rise;
  logic              scan_start;
  logic              step;
  logic              scan_end;
  logic              running;

  sweep_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (trig_in),
    .rise_o   (trig_rise)
  );

  assign running    = (state_q == SW_RUN);
  assign scan_start = trig_rise && !running;

  sweep_pacer #(.IVL_W(IVL_W)) u_pacer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (scan_start),
    .run      (running),
    .ext_mode (ext_pace),
    .ext_evt  (trig_rise),
    .interval (step_interval),
    .step_o   (step)
  );

  assign scan_end = (scan_start && num_steps == '0) ||
                    (step && left_q == STEP_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SW_IDLE;
      freq_q  <= '0;
      left_q  <= '0;
    end else if (scan_start) begin
      freq_q  <= start_freq;
      left_q  <= num_steps;
      state_q <= (num_steps == '0) ? SW_DONE : SW_RUN;
    end else if (step) begin
      freq_q <= freq_q + delta_freq;
      left_q <= left_q - STEP_W'(1);
      if (left_q == STEP_W'(1)) state_q <= SW_DONE;
    end
  end

  sweep_sync_gen #(.PULSE_LEN(PULSE_LEN)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_evt   (step),
    .scan_start (scan_start),
    .scan_end   (scan_end),
    .eos_mode   (sync_eos_mode),
    .enable     (sync_en),
    .sync_o     (sync_out),
    .sync_oe_o  (sync_oe)
  );

  assign freq_word = freq_q;
  assign scan_busy = running;
  assign scan_done = (state_q == SW_DONE);

  // R3
  run_has_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (left_q != '0));

  // R3
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SW_DONE && !trig_rise) |=> $stable(freq_q));
endmodule

// File: tb/test_freq_sweep_ctrl.sv
module test_freq_sweep_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_in = 1'b0;
  logic        ext_pace = 1'b0;
  logic        sync_eos_mode = 1'b0;
  logic        sync_en = 1'b1;
  logic [23:0] start_freq = '0;
  logic [23:0] delta_freq = '0;
  logic [11:0] num_steps = '0;
  logic [15:0] step_interval = '0;
  logic [23:0] freq_word;
  logic        scan_busy, scan_done, sync_out, sync_oe;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  freq_sweep_ctrl i_freq_sweep_ctrl (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .ext_pace(ext_pace),
    .sync_eos_mode(sync_eos_mode), .sync_en(sync_en),
    .start_freq(start_freq), .delta_freq(delta_freq),
    .num_steps(num_steps), .step_interval(step_interval),
    .freq_word(freq_word), .scan_busy(scan_busy), .scan_done(scan_done),
    .sync_out(sync_out), .sync_oe(sync_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // raise trigger at a negedge, sample after the third rising edge
  task automatic raise_and_wait();
    @(negedge clk);
    trig_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drop_trig();
    trig_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 reset freq", 32'(freq_word), 32'h0);
    chk("R1 reset busy", 32'(scan_busy), 32'h0);
    chk("R1 reset done", 32'(scan_done), 32'h0);
    chk("R1 reset sync", 32'(sync_out), 32'h0);
    chk("R8 oe enabled", 32'(sync_oe), 32'h1);
  endtask

  task automatic t_internal();
    logic [23:0] exp_f;
    ext_pace = 1'b0; sync_eos_mode = 1'b0; sync_en = 1'b1;
    step_interval = 16'd6; num_steps = 12'd3;
    start_freq = 24'h000100; delta_freq = 24'h000010;
    raise_and_wait();
    chk("R1 start load", 32'(freq_word), 32'h100);
    chk("R1 busy", 32'(scan_busy), 32'h1);
    trig_in = 1'b0;
    exp_f = 24'h000100;
    for (int s = 0; s < 3; s++) begin
      for (int n = 1; n <= 7; n++) begin
        @(negedge clk);
        if (s == 1 && n == 2) trig_in = 1'b1;   // R4 stray trigger ignored
        if (s == 1 && n == 5) trig_in = 1'b0;
        if (n < 7) begin
          chk("R4 no early step", 32'(freq_word), 32'(exp_f));
          chk("R6 pulse shape", 32'(sync_out), 32'((s > 0) && (n <= 3)));
        end else begin
          exp_f = exp_f + 24'h000010;
          chk("R4 step period", 32'(freq_word), 32'(exp_f));
          chk("R6 pulse at step", 32'(sync_out), 32'h1);
        end
      end
    end
    chk("R3 done after count", 32'(scan_done), 32'h1);
    chk("R3 busy falls", 32'(scan_busy), 32'h0);
    repeat (5) @(negedge clk);
    chk("R3 word held", 32'(freq_word), 32'h130);
  endtask

  task automatic t_wrap();
    ext_pace = 1'b0; sync_eos_mode = 1'b1;
    step_interval = 16'd0; num_steps = 12'd2;
    start_freq = 24'hFFFFF0; delta_freq = 24'h000020;
    @(negedge clk);
    chk("R7 level held from prior end", 32'(sync_out), 32'h1);
    raise_and_wait();
    chk("R1 start load near top", 32'(freq_word), 32'hFFFFF0);
    chk("R7 cleared at start", 32'(sync_out), 32'h0);
    trig_in = 1'b0;
    @(negedge clk);
    chk("R2 wrap step", 32'(freq_word), 32'h000010);
    chk("R7 low mid scan", 32'(sync_out), 32'h0);
    @(negedge clk);
    chk("R2 second step", 32'(freq_word), 32'h000030);
    chk("R7 high at end", 32'(sync_out), 32'h1);
    chk("R3 done", 32'(scan_done), 32'h1);
    repeat (3) @(negedge clk);
    chk("R7 level stays", 32'(sync_out), 32'h1);
    raise_and_wait();
    chk("R9 restart load", 32'(freq_word), 32'hFFFFF0);
    chk("R9 restart busy", 32'(scan_busy), 32'h1);
    chk("R7 cleared on restart", 32'(sync_out), 32'h0);
    drop_trig();
    chk("R9 restart completes", 32'(freq_word), 32'h000030);
  endtask

  task automatic t_external();
    ext_pace = 1'b1; sync_eos_mode = 1'b0;
    step_interval = 16'd2; num_steps = 12'd3;
    start_freq = 24'h000005; delta_freq = 24'h000007;
    raise_and_wait();
    chk("R1 ext start", 32'(freq_word), 32'h5);
    repeat (6) @(negedge clk);
    chk("R5 held trigger no step", 32'(freq_word), 32'h5);
    drop_trig();
    chk("R5 no step before edge", 32'(freq_word), 32'h5);
    for (int k = 1; k <= 3; k++) begin
      raise_and_wait();
      chk("R5 one step per edge", 32'(freq_word), 32'(24'h5 + 24'(7 * k)));
      chk("R6 pulse on ext step", 32'(sync_out), 32'h1);
      drop_trig();
      chk("R5 stable between edges", 32'(freq_word), 32'(24'h5 + 24'(7 * k)));
    end
    chk("R3 ext done", 32'(scan_done), 32'h1);
  endtask

  task automatic t_zero();
    ext_pace = 1'b0; sync_eos_mode = 1'b1;
    num_steps = 12'd0; start_freq = 24'h0ABCDE;
    raise_and_wait();
    chk("R3 zero steps load", 32'(freq_word), 32'h0ABCDE);
    chk("R3 zero steps done", 32'(scan_done), 32'h1);
    chk("R3 zero steps not busy", 32'(scan_busy), 32'h0);
    chk("R7 zero steps level", 32'(sync_out), 32'h1);
    drop_trig();
  endtask

  task automatic t_disable();
    sync_en = 1'b0; sync_eos_mode = 1'b0; ext_pace = 1'b0;
    num_steps = 12'd1; step_interval = 16'd1;
    start_freq = 24'h000200; delta_freq = 24'h000001;
    @(negedge clk);
    chk("R8 oe low", 32'(sync_oe), 32'h0);
    raise_and_wait();
    trig_in = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 step still happens", 32'(freq_word), 32'h201);
    chk("R8 sync quiet", 32'(sync_out), 32'h0);
    chk("R8 oe stays low", 32'(sync_oe), 32'h0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_internal();
    t_wrap();
    t_external();
    t_zero();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule